// File: doc/BRIEF.md
# DDR SDRAM Command State Controller

This block is the control core of a four-bank double data rate SDRAM device model. On every rising clock edge it samples the clock enable, chip select, the three command strobes, the bank select and the multiplexed address. It turns each legal command into state changes and datapath strobes. It tracks, for every bank, whether a row is open and which one. It latches the mode word, runs the burst of the current read or write, and handles the low-power states entered through the clock enable.

Commands that break the protocol raise a one-cycle error flag and leave every piece of state untouched. Examples are opening a bank that already has an open row, or accessing a closed bank. The datapath that surrounds the block uses the read and write burst levels, the refresh pulse and the latched access bank, row and column. Analog behaviour, delay-locked loops and array timing are outside its scope.

Top module: `ddr_cmd_ctrl`

## Requirements
- R1: An asserted reset (rst_n low) clears the state at once: all banks closed, no burst, power mode 0 (running), mode word 0, error and refresh outputs low.
- R2: With cs_n high at an edge, the strobes are ignored as a new command. A burst already in progress keeps running to its end.
- R3: The command code is {ras_n,cas_n,we_n}: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. An activate opens bank ba and stores addr as its row. An activate to an open bank raises cmd_err for one cycle and changes no state.
- R4: A read or write to an open bank starts a burst. rd_burst or wr_burst stays high for the burst length in clock cycles, starting the cycle after the command edge, and acc_bank, acc_row and acc_col (addr[7:0]) are latched. A read or write to a closed bank raises cmd_err. A new read or write to an open bank cuts short a running burst that has no auto-precharge.
- R5: addr[8] high on a read or write requests auto-precharge. The bank closes at the same edge where its burst ends.
- R6: A precharge closes bank ba, or all banks when addr[8] is high. Precharging a closed bank is not an error.
- R7: A mode set is accepted only with all banks closed and no burst running, and it loads addr into mode_word; otherwise it raises cmd_err. The burst length in clock cycles comes from mode_word[2:0]: 1 gives 1 cycle, 2 gives 2, 3 gives 4, 7 gives full page (128), and any other code gives 1.
- R8: A refresh with all banks closed and no burst running gives a one-cycle ref_pulse; otherwise it raises cmd_err.
- R9: A burst stop ends a running read at its edge. It has no effect on a write burst or when nothing is running.
- R10: cke low at an edge in running mode, with no burst running, enters a low-power state. pwr_mode becomes 1 (idle power-down) with all banks closed, 2 (active power-down) with any bank open, or 3 (self refresh) when the sampled command is refresh and all banks are closed. While a burst runs, cke low is ignored.
- R11: In any low-power state all commands are ignored. cke high returns pwr_mode to 0 at that edge, and the command sampled at that edge is also ignored.
- R12: While a burst with auto-precharge runs, a read, a write or a burst stop raises cmd_err and leaves the burst running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| cke | input | 1 | Clock enable, low requests a low-power state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, command bit 2 |
| cas_n | input | 1 | Column strobe, command bit 1 |
| we_n | input | 1 | Write strobe, command bit 0 |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address, column address in bits 7:0, bit 8 auto/all-bank precharge |
| cmd_err | output | 1 | One-cycle flag for an illegal command |
| ref_pulse | output | 1 | One-cycle pulse for an accepted refresh |
| rd_burst | output | 1 | High while a read burst runs |
| wr_burst | output | 1 | High while a write burst runs |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| pwr_mode | output | 2 | 0 running, 1 idle power-down, 2 active power-down, 3 self refresh |
| mode_word | output | 12 | Last accepted mode set value |
| acc_bank | output | 2 | Bank of the last accepted read or write |
| acc_row | output | 12 | Open row of that bank at the access |
| acc_col | output | 8 | Column of the last accepted read or write |

## Verification
Any corrupted bank flag shows up within one cycle of the next command to that bank. It appears either as a spurious or missing cmd_err on activate, read or write, or directly on bank_open. A wrong burst counter shows as a rd_burst or wr_burst level of the wrong length. If the counter loses its auto-precharge mark, the bank stays open after the burst ends. Power-mode errors show on pwr_mode one cycle after the cke edge, and they show on the swallowed or accepted commands that follow.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'd0, CMD_REF = 3'd1, CMD_PRE = 3'd2, CMD_ACT = 3'd3,
    CMD_WR  = 3'd4, CMD_RD  = 3'd5, CMD_BST = 3'd6, CMD_NOP = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN = 2'd0, PWR_IDLE_PD = 2'd1, PWR_ACT_PD = 2'd2, PWR_SELF_REF = 2'd3
  } pwr_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = CMD_NOP;
    else      cmd = cmd_e'({ras_n, cas_n, we_n});
  end
endmodule

// File: rtl/ddr_bank_file.sv
`timescale 1ns/1ps
module ddr_bank_file #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 open_req,
  input  logic [BA_W-1:0]      open_bank,
  input  logic [ROW_W-1:0]     open_row,
  input  logic [NUM_BANKS-1:0] close_mask,
  input  logic [BA_W-1:0]      look_bank,
  output logic [NUM_BANKS-1:0] open_vec,
  output logic [ROW_W-1:0]     look_row
);
  logic [ROW_W-1:0] row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic open_d;
    logic row_en;

    always_comb begin
      row_en = open_req && (open_bank == BA_W'(b));
      open_d = open_vec[b];
      if (close_mask[b]) open_d = 1'b0;
      if (row_en)        open_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_vec[b] <= 1'b0;
      else        open_vec[b] <= open_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[b] <= '0;
      else if (row_en) row_q[b] <= open_row;
    end
  end

  assign look_row = row_q[look_bank];

  // R3
  open_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |-> !open_vec[open_bank]);
endmodule

// File: rtl/ddr_burst_ctr.sv
`timescale 1ns/1ps
module ddr_burst_ctr #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 8,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic             start_ap,
  input  logic [BA_W-1:0]  start_bank,
  input  logic [CNT_W-1:0] start_len,
  input  logic             stop,
  output logic             active,
  output logic             is_rd,
  output logic             ap_pend,
  output logic             close_now,
  output logic [BA_W-1:0]  close_bank
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d, rd_q, rd_d, ap_q, ap_d;
  logic [BA_W-1:0]  bank_q, bank_d;
  logic             last;

  always_comb begin
    last   = act_q && (cnt_q == CNT_W'(1));
    cnt_d  = cnt_q;
    act_d  = act_q;
    rd_d   = rd_q;
    ap_d   = ap_q;
    bank_d = bank_q;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = start_len;
      rd_d   = start_rd;
      ap_d   = start_ap;
      bank_d = start_bank;
    end else if (stop) begin
      act_d = 1'b0;
      cnt_d = '0;
      ap_d  = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (last) begin
        act_d = 1'b0;
        ap_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      rd_q   <= rd_d;
      ap_q   <= ap_d;
      bank_q <= bank_d;
    end
  end

  assign active     = act_q;
  assign is_rd      = rd_q;
  assign ap_pend    = ap_q;
  assign close_now  = last && ap_q;
  assign close_bank = bank_q;

  // R4
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(cnt_q) == CNT_W'(1) || $past(stop)));
  // R9
  bst_rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (act_q && rd_q && !ap_q));
endmodule

// File: rtl/ddr_cmd_ctrl.sv
`timescale 1ns/1ps
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 8,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ROW_W-1:0]     addr,
  output logic                 cmd_err,
  output logic                 ref_pulse,
  output logic                 rd_burst,
  output logic                 wr_burst,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [1:0]           pwr_mode,
  output logic [ROW_W-1:0]     mode_word,
  output logic [BA_W-1:0]      acc_bank,
  output logic [ROW_W-1:0]     acc_row,
  output logic [COL_W-1:0]     acc_col
);
  localparam int CNT_W = COL_W;

  function automatic logic [CNT_W-1:0] burst_cycles(input logic [2:0] code);
    case (code)
      3'd2:    return CNT_W'(2);
      3'd3:    return CNT_W'(4);
      3'd7:    return CNT_W'(2 ** (COL_W - 1));
      default: return CNT_W'(1);
    endcase
  endfunction

  cmd_e                 cmd;
  pwr_e                 pwr_q, pwr_d;
  logic [ROW_W-1:0]     mode_q, mode_d;
  logic                 err_q, err_d, ref_q, ref_d;
  logic                 open_req, start, stop;
  logic [NUM_BANKS-1:0] pre_mask, close_mask, bank_sel;
  logic                 burst_on, burst_rd, ap_pend, close_now;
  logic [BA_W-1:0]      close_bank;
  logic [ROW_W-1:0]     look_row;
  logic                 any_open, all_quiet;
  logic [BA_W-1:0]      abank_q;
  logic [ROW_W-1:0]     arow_q;
  logic [COL_W-1:0]     acol_q;

  ddr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  ddr_bank_file #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .open_bank(ba),
    .open_row(addr), .close_mask(close_mask), .look_bank(ba),
    .open_vec(bank_open), .look_row(look_row)
  );

  ddr_burst_ctr #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(cmd == CMD_RD),
    .start_ap(addr[AP_BIT]), .start_bank(ba),
    .start_len(burst_cycles(mode_q[2:0])), .stop(stop),
    .active(burst_on), .is_rd(burst_rd), .ap_pend(ap_pend),
    .close_now(close_now), .close_bank(close_bank)
  );

  assign bank_sel   = NUM_BANKS'(1) << ba;
  assign close_mask = pre_mask | (close_now ? (NUM_BANKS'(1) << close_bank) : '0);

  always_comb begin
    any_open  = |bank_open;
    all_quiet = !any_open && !burst_on;
    pwr_d     = pwr_q;
    mode_d    = mode_q;
    err_d     = 1'b0;
    ref_d     = 1'b0;
    open_req  = 1'b0;
    start     = 1'b0;
    stop      = 1'b0;
    pre_mask  = '0;
    if (pwr_q != PWR_RUN) begin
      if (cke) pwr_d = PWR_RUN;
    end else if (!cke && !burst_on) begin
      if (any_open)            pwr_d = PWR_ACT_PD;
      else if (cmd == CMD_REF) pwr_d = PWR_SELF_REF;
      else                     pwr_d = PWR_IDLE_PD;
    end else begin
      case (cmd)
        CMD_MRS: if (all_quiet) mode_d = addr; else err_d = 1'b1;
        CMD_REF: if (all_quiet) ref_d = 1'b1;  else err_d = 1'b1;
        CMD_PRE: pre_mask = addr[AP_BIT] ? '1 : bank_sel;
        CMD_ACT: if (bank_open[ba]) err_d = 1'b1; else open_req = 1'b1;
        CMD_WR, CMD_RD: begin
          if (!bank_open[ba] || ap_pend) err_d = 1'b1;
          else                           start = 1'b1;
        end
        CMD_BST: begin
          if (burst_on && burst_rd) begin
            if (ap_pend) err_d = 1'b1;
            else         stop  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= PWR_RUN;
      mode_q <= '0;
      err_q  <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      pwr_q  <= pwr_d;
      mode_q <= mode_d;
      err_q  <= err_d;
      ref_q  <= ref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abank_q <= '0;
      arow_q  <= '0;
      acol_q  <= '0;
    end else if (start) begin
      abank_q <= ba;
      arow_q  <= look_row;
      acol_q  <= addr[COL_W-1:0];
    end
  end

  assign cmd_err   = err_q;
  assign ref_pulse = ref_q;
  assign rd_burst  = burst_on && burst_rd;
  assign wr_burst  = burst_on && !burst_rd;
  assign pwr_mode  = pwr_q;
  assign mode_word = mode_q;
  assign acc_bank  = abank_q;
  assign acc_row   = arow_q;
  assign acc_col   = acol_q;

  // R10
  sref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q == PWR_SELF_REF) |-> (bank_open == '0 && !burst_on));
  // R11
  lp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q != PWR_RUN && !cke) |=> $stable(bank_open));
  // R8
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q |-> (bank_open == '0 && !burst_on));
  // R7
  err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(mode_q));
endmodule

// File: tb/ddr_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module ddr_cmd_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        cmd_err, ref_pulse, rd_burst, wr_burst;
  logic [3:0]  bank_open;
  logic [1:0]  pwr_mode;
  logic [11:0] mode_word, acc_row;
  logic [1:0]  acc_bank;
  logic [7:0]  acc_col;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_err(cmd_err),
    .ref_pulse(ref_pulse), .rd_burst(rd_burst), .wr_burst(wr_burst),
    .bank_open(bank_open), .pwr_mode(pwr_mode), .mode_word(mode_word),
    .acc_bank(acc_bank), .acc_row(acc_row), .acc_col(acc_col)
  );

  // [31:28] req, [27] cke, [26] cs_n, [25:23] cmd, [22:21] ba, [20:9] addr,
  // [8:5] bank_open, [4] rd, [3] wr, [2] err, [1:0] pwr
  localparam logic [31:0] VEC [44] = '{
    {4'd1, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R1 nop
    {4'd7, 1'b1,1'b0,3'd0,2'd0,12'h002, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R7 mode BL 2 cyc
    {4'd3, 1'b1,1'b0,3'd3,2'd0,12'h123, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R3 act b0
    {4'd3, 1'b1,1'b0,3'd3,2'd0,12'h456, 4'b0001,1'b0,1'b0,1'b1,2'd0}, // R3 act open
    {4'd4, 1'b1,1'b0,3'd5,2'd0,12'h010, 4'b0001,1'b1,1'b0,1'b0,2'd0}, // R4 read
    {4'd4, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0001,1'b1,1'b0,1'b0,2'd0}, // R4
    {4'd4, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R4 end
    {4'd4, 1'b1,1'b0,3'd5,2'd1,12'h000, 4'b0001,1'b0,1'b0,1'b1,2'd0}, // R4 closed bank
    {4'd3, 1'b1,1'b0,3'd3,2'd2,12'h0AB, 4'b0101,1'b0,1'b0,1'b0,2'd0}, // R3 act b2
    {4'd5, 1'b1,1'b0,3'd4,2'd2,12'h105, 4'b0101,1'b0,1'b1,1'b0,2'd0}, // R5 write ap
    {4'd2, 1'b1,1'b1,3'd3,2'd1,12'h000, 4'b0101,1'b0,1'b1,1'b0,2'd0}, // R2 cs high
    {4'd5, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R5 closes
    {4'd7, 1'b1,1'b0,3'd0,2'd0,12'h003, 4'b0001,1'b0,1'b0,1'b1,2'd0}, // R7 bank open
    {4'd8, 1'b1,1'b0,3'd1,2'd0,12'h000, 4'b0001,1'b0,1'b0,1'b1,2'd0}, // R8 bank open
    {4'd4, 1'b1,1'b0,3'd5,2'd0,12'h000, 4'b0001,1'b1,1'b0,1'b0,2'd0}, // R4 read
    {4'd9, 1'b1,1'b0,3'd6,2'd0,12'h000, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R9 stop
    {4'd4, 1'b1,1'b0,3'd4,2'd0,12'h000, 4'b0001,1'b0,1'b1,1'b0,2'd0}, // R4 write
    {4'd9, 1'b1,1'b0,3'd6,2'd0,12'h000, 4'b0001,1'b0,1'b1,1'b0,2'd0}, // R9 no effect
    {4'd4, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R4 end
    {4'd6, 1'b1,1'b0,3'd2,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R6 pre b0
    {4'd3, 1'b1,1'b0,3'd3,2'd1,12'h011, 4'b0010,1'b0,1'b0,1'b0,2'd0}, // R3
    {4'd3, 1'b1,1'b0,3'd3,2'd3,12'h033, 4'b1010,1'b0,1'b0,1'b0,2'd0}, // R3
    {4'd6, 1'b1,1'b0,3'd2,2'd0,12'h100, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R6 pre all
    {4'd8, 1'b1,1'b0,3'd1,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R8 refresh ok
    {4'd10,1'b0,1'b0,3'd7,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd1}, // R10 idle pd
    {4'd11,1'b0,1'b0,3'd3,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd1}, // R11 ignored
    {4'd11,1'b1,1'b0,3'd3,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R11 exit
    {4'd10,1'b0,1'b0,3'd1,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd3}, // R10 self ref
    {4'd11,1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R11 exit
    {4'd3, 1'b1,1'b0,3'd3,2'd1,12'h022, 4'b0010,1'b0,1'b0,1'b0,2'd0}, // R3
    {4'd10,1'b0,1'b0,3'd7,2'd0,12'h000, 4'b0010,1'b0,1'b0,1'b0,2'd2}, // R10 active pd
    {4'd11,1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0010,1'b0,1'b0,1'b0,2'd0}, // R11 exit
    {4'd5, 1'b1,1'b0,3'd5,2'd1,12'h100, 4'b0010,1'b1,1'b0,1'b0,2'd0}, // R5 read ap
    {4'd12,1'b1,1'b0,3'd5,2'd1,12'h000, 4'b0010,1'b1,1'b0,1'b1,2'd0}, // R12 read err
    {4'd5, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R5 closes
    {4'd3, 1'b1,1'b0,3'd3,2'd1,12'h022, 4'b0010,1'b0,1'b0,1'b0,2'd0}, // R3
    {4'd5, 1'b1,1'b0,3'd5,2'd1,12'h100, 4'b0010,1'b1,1'b0,1'b0,2'd0}, // R5 read ap
    {4'd12,1'b1,1'b0,3'd6,2'd0,12'h000, 4'b0010,1'b1,1'b0,1'b1,2'd0}, // R12 stop err
    {4'd5, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0000,1'b0,1'b0,1'b0,2'd0}, // R5 closes
    {4'd3, 1'b1,1'b0,3'd3,2'd0,12'h044, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R3
    {4'd4, 1'b1,1'b0,3'd4,2'd0,12'h000, 4'b0001,1'b0,1'b1,1'b0,2'd0}, // R4 write
    {4'd10,1'b0,1'b0,3'd7,2'd0,12'h000, 4'b0001,1'b0,1'b1,1'b0,2'd0}, // R10 cke ignored
    {4'd4, 1'b1,1'b0,3'd7,2'd0,12'h000, 4'b0001,1'b0,1'b0,1'b0,2'd0}, // R4 end
    {4'd6, 1'b1,1'b0,3'd2,2'd2,12'h100, 4'b0000,1'b0,1'b0,1'b0,2'd0}  // R6 pre all
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic k, input logic cs, input logic [2:0] c,
                     input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    ba = '0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "bank_open", 32'(bank_open), 0);
    chk("R1", "bursts/err/ref", {rd_burst, wr_burst, cmd_err, ref_pulse}, 0);
    chk("R1", "pwr_mode", 32'(pwr_mode), 0);
    chk("R1", "mode_word", 32'(mode_word), 0);

    for (int i = 0; i < 44; i++) begin
      logic [31:0] v;
      v = VEC[i];
      cyc(v[27], v[26], v[25:23], v[22:21], v[20:9]);
      chk($sformatf("R%0d", v[31:28]), $sformatf("vector %0d", i),
          {bank_open, rd_burst, wr_burst, cmd_err, pwr_mode}, 32'(v[8:0]));
    end

    // R7 mode load and 4-cycle burst length (code 3)
    cyc(1, 0, 3'd0, 0, 12'h033);
    chk("R7", "mode_word", 32'(mode_word), 32'h033);
    cyc(1, 0, 3'd3, 2, 12'hABC);
    cyc(1, 0, 3'd5, 2, 12'h05A);
    // R4 latched access fields
    chk("R4", "acc_bank", 32'(acc_bank), 2);
    chk("R4", "acc_row", 32'(acc_row), 32'hABC);
    chk("R4", "acc_col", 32'(acc_col), 32'h5A);
    n = 0;
    while (rd_burst && n < 300) begin n++; cyc(1, 0, 3'd7, 0, 0); end
    chk("R7", "read burst cycles code 3", n, 4);
    // R8 refresh rejected while open, then pulse
    cyc(1, 0, 3'd1, 0, 0);
    chk("R8", "refresh with open bank err", 32'({cmd_err, ref_pulse}), 2);
    cyc(1, 0, 3'd2, 0, 12'h100);
    cyc(1, 0, 3'd1, 0, 0);
    chk("R8", "ref_pulse", 32'({cmd_err, ref_pulse}), 1);
    cyc(1, 0, 3'd7, 0, 0);
    chk("R8", "ref_pulse one cycle", 32'(ref_pulse), 0);
    // R7 full page
    cyc(1, 0, 3'd0, 0, 12'h007);
    cyc(1, 0, 3'd3, 3, 12'h001);
    cyc(1, 0, 3'd4, 3, 12'h000);
    n = 0;
    while (wr_burst && n < 300) begin n++; cyc(1, 0, 3'd7, 0, 0); end
    chk("R7", "write burst cycles full page", n, 128);
    // R1 asynchronous reset mid-burst
    cyc(1, 0, 3'd4, 3, 12'h000);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1", "open after reset", 32'(bank_open), 0);
    chk("R1", "burst after reset", 32'({rd_burst, wr_burst}), 0);
    chk("R1", "mode after reset", 32'(mode_word), 0);
    @(negedge clk) rst_n = 1'b1;
    done = 1'b1;
    finish_up();
  end
endmodule